// File: doc/BRIEF.md
# Nested Interrupt Priority Tracker

This block keeps a record of the fast-interrupt priority levels that are in service when handlers are allowed to nest. There are eight levels. Level 0 is the most urgent and level 7 the least urgent. When nesting is on and software fetches the vector, the priority of the request being served is recorded as a set bit in an 8-bit service register. As long as any level is recorded, the block stops requests at that level and at every less urgent level from reaching the masked request output.

Software ends a handler by writing the service register. Each write retires exactly one level, the most urgent one that is recorded, and the written value makes no difference. Nested levels therefore always unwind in order, one level per write. A one-bit control register turns nesting on and off. While nesting is off, vector fetches record nothing and the raw requests pass through unchanged.

Top module: `nest_prio_tracker`

## Requirements
- R1: After reset, the service register (address 0) reads 0 and the control register (address 1) reads 0, which means nesting is off.
- R2: With nesting on, a vector-read strobe carrying priority p sets service bit p. The new value can be read one clock edge later.
- R3: With nesting on and L the lowest-index set service bit, req_masked equals req_raw with every bit at index L or above forced to 0. With no service bit set, req_masked equals req_raw. The output follows these values in the same cycle.
- R4: A write to address 0 clears only the lowest-index set service bit, whatever data is written. From 0x09, one write gives 0x08 and a second write gives 0x00.
- R5: A write to address 0 while the service register is 0 leaves it at 0.
- R6: With nesting off (control bit 0 = 0), a vector-read strobe sets no service bit and req_masked equals req_raw. Service bits that are already set are kept.
- R7: A vector-read strobe and a write to address 0 in the same cycle first retire the lowest-index set bit and then set the strobed bit. From 0x06 with priority 0, the result is 0x05.
- R8: Bits 31:8 of the service register and bits 31:1 of the control register always read 0. A write of 0xFFFFFFFF to address 1 reads back as 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = service register, 1 = control register |
| reg_wdata | input | 32 | Write data. Only bit 0 is used, and only for the control register |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| vec_rd | input | 1 | Vector-read strobe |
| vec_prio | input | 3 | Priority of the request being served when vec_rd is high |
| req_raw | input | 8 | Raw requests, one bit per priority level |
| req_masked | output | 8 | Requests after priority blocking |

## Verification
Every register effect is due one clock edge after its write or strobe: the service bits, the nesting enable and the same-cycle clear-then-set. The masked output and the read data are combinational, so they follow the register state within the same cycle. The bench applies each stimulus on a falling edge and removes it on the next falling edge, so exactly one rising edge falls between the two. It then reads the register or sets req_raw and samples one time unit later, well away from any rising edge.

// File: rtl/nest_prio_tracker.sv
module nest_prio_tracker #(
  parameter int LEVELS = 8,
  parameter int DATA_W = 32,
  localparam int PRIO_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vec_rd,
  input  logic [PRIO_W-1:0] vec_prio,
  input  logic [LEVELS-1:0] req_raw,
  output logic [LEVELS-1:0] req_masked
);

  logic [LEVELS-1:0] stat_q, stat_clr, set_vec, block;
  logic              nest_q;
  logic              stat_wr, ctrl_wr;
  logic              unused_wdata;

  assign stat_wr = reg_wr && !reg_addr;
  assign ctrl_wr = reg_wr && reg_addr;
  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  // retire the most urgent level, then record the newly served one
  assign stat_clr = stat_wr ? (stat_q & (stat_q - 1'b1)) : stat_q;
  assign set_vec  = (nest_q && vec_rd) ? (LEVELS'(1) << vec_prio) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      nest_q <= 1'b0;
    end else begin
      stat_q <= stat_clr | set_vec;
      if (ctrl_wr) nest_q <= reg_wdata[0];
    end
  end

  assign block[0] = stat_q[0];
  for (genvar i = 1; i < LEVELS; i++) begin : g_blk
    assign block[i] = block[i-1] | stat_q[i];
  end

  assign req_masked = nest_q ? (req_raw & ~block) : req_raw;

  assign reg_rdata = reg_addr ? {{(DATA_W-1){1'b0}}, nest_q}
                              : {{(DATA_W-LEVELS){1'b0}}, stat_q};

endmodule

module nest_prio_tracker_chk #(
  parameter int LEVELS = 8,
  parameter int DATA_W = 32,
  localparam int PRIO_W = $clog2(LEVELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              vec_rd,
  input logic [PRIO_W-1:0] vec_prio,
  input logic [LEVELS-1:0] req_raw,
  input logic [LEVELS-1:0] req_masked,
  input logic [LEVELS-1:0] stat_q,
  input logic              nest_q
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:LEVELS] == '0); // R8

  AST_SET_ON_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q && vec_rd) |=> stat_q[$past(vec_prio)]); // R2

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && (stat_q != '0) && !vec_rd)
      |=> ($countones(stat_q) + 1 == $past($countones(stat_q)))); // R4

  AST_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && (stat_q == '0) && !vec_rd) |=> (stat_q == '0)); // R5

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(nest_q && vec_rd) && !(reg_wr && !reg_addr)) |=> $stable(stat_q)); // R6

  AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !nest_q |-> (req_masked == req_raw)); // R6

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_masked & ~req_raw) == '0); // R3

  AST_URGENT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q && stat_q[0]) |-> (req_masked == '0)); // R3

endmodule

bind nest_prio_tracker nest_prio_tracker_chk #(.LEVELS(LEVELS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .vec_rd(vec_rd), .vec_prio(vec_prio),
  .req_raw(req_raw), .req_masked(req_masked), .stat_q(stat_q), .nest_q(nest_q)
);

// File: tb/tb_nest_prio_tracker.sv
`timescale 1ns/1ps
module tb_nest_prio_tracker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic        reg_addr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vec_rd = 0;
  logic [2:0]  vec_prio = '0;
  logic [7:0]  req_raw = '0;
  logic [7:0]  req_masked;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_stat = '0;
  logic       m_nest = 0;

  always #5 clk = ~clk;

  nest_prio_tracker dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic addr, input logic [31:0] wd,
                       input logic vr, input logic [2:0] vp);
    logic [7:0] s;
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; vec_rd = vr; vec_prio = vp;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0; vec_rd = 0;
    s = m_stat;
    if (wr && !addr) begin
      for (int i = 0; i < 8; i++) if (s[i]) begin s[i] = 0; break; end
    end
    if (vr && m_nest) s[vp] = 1'b1;
    if (wr && addr) m_nest = wd[0];
    m_stat = s;
  endtask

  task automatic read_chk(input logic addr, input logic [31:0] exp, input string tag);
    reg_addr = addr; #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] exp_mask(input logic [7:0] raw);
    logic [7:0] r = raw;
    if (!m_nest) return raw;
    for (int i = 0; i < 8; i++) if (m_stat[i]) begin
      for (int j = i; j < 8; j++) r[j] = 1'b0;
      break;
    end
    return r;
  endfunction

  task automatic mask_chk(input logic [7:0] raw, input string tag);
    req_raw = raw; #1;
    chk(tag, {24'h0, req_masked}, {24'h0, exp_mask(raw)});
  endtask

  task automatic t_reset;
    read_chk(0, 32'h0, "R1 status after reset");
    read_chk(1, 32'h0, "R1 control after reset");
    mask_chk(8'hFF, "R1 pass-through after reset");
  endtask

  task automatic t_disabled;
    drive(0, 0, 0, 1, 3'd3);
    read_chk(0, 32'h0, "R6 no set while disabled");
    mask_chk(8'hA5, "R6 pass-through disabled");
  endtask

  task automatic t_set_mask;
    drive(1, 1, 32'h1, 0, 0);
    read_chk(1, 32'h1, "R8 control enable readback");
    drive(0, 0, 0, 1, 3'd3);
    read_chk(0, 32'h08, "R2 set level 3");
    mask_chk(8'hFF, "R3 mask under level 3");
    mask_chk(8'h5A, "R3 mask pattern 5A");
    drive(0, 0, 0, 1, 3'd0);
    read_chk(0, 32'h09, "R2 set level 0");
    mask_chk(8'hFF, "R3 all blocked at level 0");
  endtask

  task automatic t_clear;
    drive(1, 0, 32'hFF, 0, 0);
    read_chk(0, 32'h08, "R4 first clear from 09");
    mask_chk(8'hFF, "R3 mask after first clear");
    drive(1, 0, 32'hFF, 0, 0);
    read_chk(0, 32'h00, "R4 second clear");
    mask_chk(8'hC3, "R3 no level set");
    drive(1, 0, 32'hFF, 0, 0);
    read_chk(0, 32'h00, "R5 write on empty");
    drive(0, 0, 0, 1, 3'd4);
    drive(0, 0, 0, 1, 3'd5);
    drive(1, 0, 32'h0, 0, 0);
    read_chk(0, 32'h20, "R4 zero data still clears one");
  endtask

  task automatic t_same_cycle;
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 3'd1);
    drive(0, 0, 0, 1, 3'd2);
    read_chk(0, {24'h0, m_stat}, "R7 setup 06");
    drive(1, 0, 32'hFF, 1, 3'd0);
    read_chk(0, 32'h05, "R7 clear then set");
    drive(1, 0, 32'hFF, 1, 3'd0);
    read_chk(0, 32'h05, "R7 clear and reset same level");
  endtask

  task automatic t_reserved;
    drive(1, 1, 32'hFFFF_FFFF, 0, 0);
    read_chk(1, 32'h1, "R8 control reserved bits");
    for (int p = 0; p < 8; p++) drive(0, 0, 0, 1, 3'(p));
    read_chk(0, 32'h0000_00FF, "R8 status reserved bits");
    drive(1, 1, 32'h0, 0, 0);
    mask_chk(8'hFF, "R6 pass-through with levels held");
    read_chk(0, 32'hFF, "R6 levels held while disabled");
    drive(0, 0, 0, 1, 3'd2);
    read_chk(0, 32'hFF, "R6 strobe ignored while disabled");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_set_mask();
    t_clear();
    t_same_cycle();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule